// File: doc/BRIEF.md
# Peripheral Clock Generator with Source Select and Fractional Divider

This block produces the clock-enable stream for one downstream peripheral. It picks one of several source clock-enable streams and divides the pulse rate of that stream by a fixed-point divisor. The divisor has an integer part and a fractional part, and the width of each part is a parameter of the instance. All sources are modelled as single-cycle enables in one clock domain. Switching between truly asynchronous clocks is not handled here.

Software drives the block through two 32-bit words, one for control and one for the divider. The control word holds the run enable and the source index, and it reads back a busy flag. Inside the divider word the divisor is a packed field. Its integer part always begins at bit 12, and its fractional part sits directly below bit 12. Division is done by a phase accumulator. Every pulse on the selected source adds 2^FRAC_W to the accumulator. When the sum reaches the divisor, the divisor is taken off and one output pulse is produced. An instance built with both widths at zero bypasses the accumulator and passes the selected source straight through.

Top module: `clkgen_fracmux`

## Requirements
- R1: `out_en` pulses only while control bit 4 (run enable) is 1. When that bit is 0, no output pulse appears.
- R2: Control read-back bit 7 (busy) always equals the stored run-enable bit. Bits [3:0] read back the source index.
- R3: Control bits [3:0] select the source. Index 0 is ground and has no pin. Input bit `src_en[k]` is source k; by convention sources 1 to 3 are the reference oscillator and two test clocks. Only the selected source affects the output, and an index of NUM_SRC or more selects nothing.
- R4: The divisor is divider-word bits [12+INT_W-1 : 12-FRAC_W]. Changing other bits of the word has no effect on the output. The whole word reads back as written.
- R5: From a cleared accumulator, n pulses of the selected source give floor(n·2^FRAC_W / divisor) output pulses when the divisor is at least 2^FRAC_W.
- R6: A divisor below 2^FRAC_W gives exactly one output pulse for each source pulse.
- R7: A divisor field of zero stops the output.
- R8: An instance with INT_W = FRAC_W = 0 passes the selected source through undivided, whatever the divider word holds.
- R9: Writing either word clears the accumulator, so changing the source produces no burst of carried-over phase.
- R10: After reset both words read 0 and `out_en` is 0.
- R11: Each output pulse is registered. It appears in the cycle after the source pulse that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write data |
| div_we | input | 1 | Divider word write strobe |
| div_wdata | input | 32 | Divider word write data |
| ctl_rdata | output | 32 | Control word read-back, with busy in bit 7 |
| div_rdata | output | 32 | Divider word read-back |
| src_en | input | NUM_SRC-1 | Source enables; bit k is source k (k = 1 to NUM_SRC-1) |
| out_en | output | 1 | Divided clock-enable for the peripheral |

## Verification
A write to either word takes effect at the clock edge that captures the strobe. An output pulse appears one edge after the source pulse that produced it. The bench drives inputs and samples outputs on falling edges. Each case counts output pulses over all of its source cycles plus two trailing idle cycles, so every pulse that is due gets counted. Read-back values are checked half a cycle after the capturing edge. Reset release passes through a two-stage synchronizer, and the bench waits for it to settle before it makes any check.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
  localparam int CTL_SRC_LSB  = 0;
  localparam int CTL_SRC_W    = 4;
  localparam int CTL_EN_BIT   = 4;
  localparam int CTL_BUSY_BIT = 7;
  localparam int DIV_INT_LSB  = 12;
endpackage

// File: rtl/clkgen_regs.sv
module clkgen_regs
  import clkgen_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctl_we,
  input  logic [31:0]          ctl_wdata,
  input  logic                 div_we,
  input  logic [31:0]          div_wdata,
  output logic [31:0]          ctl_rdata,
  output logic [31:0]          div_rdata,
  output logic                 enable,
  output logic [CTL_SRC_W-1:0] src_sel,
  output logic                 acc_clr
);
  logic [31:0] ctl_q, ctl_d;
  logic [31:0] div_q, div_d;

  always_comb begin
    ctl_d = ctl_we ? ctl_wdata : ctl_q;
    div_d = div_we ? div_wdata : div_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      div_q <= '0;
    end else begin
      if (ctl_we) ctl_q <= ctl_d;
      if (div_we) div_q <= div_d;
    end
  end

  assign enable  = ctl_q[CTL_EN_BIT];
  assign src_sel = ctl_q[CTL_SRC_LSB +: CTL_SRC_W];
  assign acc_clr = ctl_we | div_we;

  always_comb begin
    ctl_rdata = ctl_q;
    ctl_rdata[CTL_BUSY_BIT] = enable;
  end
  assign div_rdata = div_q;

  AST_EN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (ctl_rdata[CTL_BUSY_BIT] == $past(ctl_wdata[CTL_EN_BIT]))); // R2
endmodule

// File: rtl/clkgen_srcsel.sv
module clkgen_srcsel
  import clkgen_pkg::*;
#(
  parameter int NUM_SRC = 6
) (
  input  logic [NUM_SRC-1:1]   src_en,
  input  logic [CTL_SRC_W-1:0] src_sel,
  output logic                 sel_en
);
  logic [NUM_SRC-1:0] src_vec;

  assign src_vec[0] = 1'b0;
  generate
    for (genvar k = 1; k < NUM_SRC; k++) begin : g_src
      assign src_vec[k] = src_en[k];
    end
  endgenerate

  always_comb begin
    sel_en = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (src_sel == CTL_SRC_W'(i)) sel_en = src_vec[i];
    end
  end
endmodule

// File: rtl/clkgen_accum.sv
module clkgen_accum #(
  parameter int INT_W   = 4,
  parameter int FRAC_W  = 4,
  parameter int FIELD_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               sel_en,
  input  logic               clr,
  input  logic [FIELD_W-1:0] div_field,
  output logic               out_en
);
  localparam int DIV_W = INT_W + FRAC_W;
  localparam int ACC_W = FIELD_W + 1;

  logic out_d, out_q;
  assign out_en = out_q;

  generate
    if (DIV_W == 0) begin : g_pass
      always_comb out_d = enable & sel_en;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= out_d;
      end
    end else begin : g_frac
      localparam logic [ACC_W-1:0] STEP = ACC_W'(1) << FRAC_W;

      logic [ACC_W-1:0] acc_q, acc_d, sum, div_ext;
      logic             run, hit, acc_upd;

      assign div_ext = {1'b0, div_field};
      assign run     = enable && (div_field != '0);
      assign sum     = acc_q + STEP;
      assign hit     = sum >= div_ext;
      assign acc_upd = clr | ~run | sel_en;

      always_comb begin
        acc_d = acc_q;
        out_d = 1'b0;
        if (clr || !run) begin
          acc_d = '0;
        end else if (sel_en) begin
          if (div_ext < STEP) begin
            acc_d = '0;
            out_d = 1'b1;
          end else if (hit) begin
            acc_d = sum - div_ext;
            out_d = 1'b1;
          end else begin
            acc_d = sum;
          end
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          acc_q <= '0;
          out_q <= 1'b0;
        end else begin
          if (acc_upd) acc_q <= acc_d;
          out_q <= out_d;
        end
      end

      AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (acc_q < div_ext) || (div_ext < STEP)); // R5
      AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_q == '0)); // R9
      AST_ZERO_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        (div_field == '0) |=> !out_en); // R7
    end
  endgenerate

  AST_DIS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !out_en); // R1
  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> $past(sel_en)); // R11
endmodule

// File: rtl/clkgen_fracmux.sv
module clkgen_fracmux
  import clkgen_pkg::*;
#(
  parameter int NUM_SRC = 6,
  parameter int INT_W   = 4,
  parameter int FRAC_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_we,
  input  logic [31:0]        ctl_wdata,
  input  logic               div_we,
  input  logic [31:0]        div_wdata,
  output logic [31:0]        ctl_rdata,
  output logic [31:0]        div_rdata,
  input  logic [NUM_SRC-1:1] src_en,
  output logic               out_en
);
  localparam int DIV_W     = INT_W + FRAC_W;
  localparam int FIELD_W   = (DIV_W == 0) ? 1 : DIV_W;
  localparam int FIELD_LSB = DIV_INT_LSB - FRAC_W;

  logic [1:0]           rst_sync;
  logic                 rst_int_n;
  logic                 enable, acc_clr, sel_en;
  logic [CTL_SRC_W-1:0] src_sel;
  logic [FIELD_W-1:0]   div_field;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  clkgen_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .div_we    (div_we),
    .div_wdata (div_wdata),
    .ctl_rdata (ctl_rdata),
    .div_rdata (div_rdata),
    .enable    (enable),
    .src_sel   (src_sel),
    .acc_clr   (acc_clr)
  );

  clkgen_srcsel #(.NUM_SRC(NUM_SRC)) u_sel (
    .src_en  (src_en),
    .src_sel (src_sel),
    .sel_en  (sel_en)
  );

  generate
    if (DIV_W > 0) begin : g_field
      assign div_field = div_rdata[FIELD_LSB +: FIELD_W];
    end else begin : g_nofield
      assign div_field = '0;
    end
  endgenerate

  clkgen_accum #(.INT_W(INT_W), .FRAC_W(FRAC_W), .FIELD_W(FIELD_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .enable    (enable),
    .sel_en    (sel_en),
    .clr       (acc_clr),
    .div_field (div_field),
    .out_en    (out_en)
  );

  AST_GND_SILENT: assert property (@(posedge clk) disable iff (!rst_int_n)
    (src_sel == '0) |-> !sel_en); // R3
endmodule

// File: tb/test_clkgen_fracmux.sv
`timescale 1ns/1ps
module test_clkgen_fracmux;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_we, div_we;
  logic [31:0] ctl_wdata, div_wdata;
  logic [31:0] ctl_rdata, div_rdata, ctl_rdata_pt, div_rdata_pt;
  logic [5:1]  src_en;
  logic        out_en, out_en_pt;
  int          checks = 0;
  int          errors = 0;

  always #5 clk = ~clk;

  clkgen_fracmux #(.NUM_SRC(6), .INT_W(4), .FRAC_W(4)) i_clkgen_fracmux (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .div_we(div_we), .div_wdata(div_wdata), .ctl_rdata(ctl_rdata),
    .div_rdata(div_rdata), .src_en(src_en), .out_en(out_en));

  clkgen_fracmux #(.NUM_SRC(6), .INT_W(0), .FRAC_W(0)) i_clkgen_fracmux_pt (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .div_we(div_we), .div_wdata(div_wdata), .ctl_rdata(ctl_rdata_pt),
    .div_rdata(div_rdata_pt), .src_en(src_en), .out_en(out_en_pt));

  typedef struct packed {
    logic [3:0]  sel;
    logic [4:0]  mask;
    logic [31:0] divw;
    logic [7:0]  n;
    logic [7:0]  exp;
  } vec_t;

  // divisor field is divider bits [15:8], units of 1/16
  localparam vec_t TBL [10] = '{
    '{4'd1, 5'b00001, 32'h0000_1000, 8'd20, 8'd20},  // R5 divide by 1.0
    '{4'd1, 5'b00001, 32'h0000_2000, 8'd20, 8'd10},  // R5 divide by 2.0
    '{4'd2, 5'b00010, 32'h0000_1800, 8'd30, 8'd20},  // R5 divide by 1.5
    '{4'd3, 5'b00100, 32'h0000_3000, 8'd30, 8'd10},  // R5 divide by 3.0
    '{4'd5, 5'b10000, 32'h0000_1400, 8'd25, 8'd20},  // R5 divide by 1.25
    '{4'd2, 5'b00100, 32'h0000_1000, 8'd10, 8'd0},   // R3 unselected source
    '{4'd0, 5'b11111, 32'h0000_1000, 8'd10, 8'd0},   // R3 ground index
    '{4'd1, 5'b00001, 32'h0000_0800, 8'd10, 8'd10},  // R6 divisor 0.5
    '{4'd4, 5'b01000, 32'h0000_FF00, 8'd32, 8'd2},   // R5 largest divisor
    '{4'd1, 5'b00001, 32'hF00F_20F0, 8'd20, 8'd10}   // R4 bits outside field
  };

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_ctl(logic [31:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wr_div(logic [31:0] v);
    @(negedge clk); div_we = 1'b1; div_wdata = v;
    @(negedge clk); div_we = 1'b0;
  endtask

  task automatic pulses(logic [4:0] mask, int n, output int cnt, output int cnt_pt);
    cnt = 0; cnt_pt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cnt += int'(out_en); cnt_pt += int'(out_en_pt); src_en = mask;
    end
    @(negedge clk); cnt += int'(out_en); cnt_pt += int'(out_en_pt); src_en = '0;
    @(negedge clk); cnt += int'(out_en); cnt_pt += int'(out_en_pt);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int c, cp;
    rst_n = 1'b0; ctl_we = 1'b0; div_we = 1'b0;
    ctl_wdata = '0; div_wdata = '0; src_en = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    chk("R10 ctl", int'(ctl_rdata), 0);
    chk("R10 div", int'(div_rdata), 0);
    chk("R10 out", int'(out_en), 0);

    // R1 disabled: source running, divisor 1.0, enable clear
    wr_ctl(32'h0000_0001);
    wr_div(32'h0000_1000);
    chk("R2 busy clear", int'(ctl_rdata[7]), 0);
    pulses(5'b00001, 10, c, cp);
    chk("R1 disabled output", c, 0);

    // table walk
    for (int r = 0; r < 10; r++) begin
      wr_ctl(32'h10 | 32'(TBL[r].sel));
      wr_div(TBL[r].divw);
      pulses(TBL[r].mask, int'(TBL[r].n), c, cp);
      if (c != int'(TBL[r].exp))
        $display("  table row %0d mismatch", r);
      chk("table row (R3/R4/R5/R6)", c, int'(TBL[r].exp));
    end
    chk("R2 busy set", int'(ctl_rdata[7]), 1);
    chk("R2 src readback", int'(ctl_rdata[3:0]), 1);
    chk("R4 div readback", int'(div_rdata == 32'hF00F_20F0), 1);

    // R7 zero divisor stops; R8 pass-through ignores divisor
    wr_ctl(32'h0000_0011);
    wr_div(32'h0000_0000);
    pulses(5'b00001, 7, c, cp);
    chk("R7 zero divisor", c, 0);
    chk("R8 pass-through", cp, 7);

    // R11 output lags the source pulse by one cycle
    wr_div(32'h0000_1000);
    @(negedge clk); src_en = 5'b00001;
    @(negedge clk); src_en = '0;
    chk("R11 pulse one cycle later", int'(out_en), 1);
    @(negedge clk);
    chk("R11 single pulse", int'(out_en), 0);

    // R9 source change clears carried phase
    wr_div(32'h0000_2000);
    c = 0;
    @(negedge clk); src_en = 5'b00001;
    @(negedge clk); c += int'(out_en); src_en = '0;
    @(negedge clk); c += int'(out_en); ctl_we = 1'b1; ctl_wdata = 32'h12;
    @(negedge clk); c += int'(out_en); ctl_we = 1'b0; src_en = 5'b00010;
    @(negedge clk); c += int'(out_en); src_en = '0;
    @(negedge clk); c += int'(out_en);
    chk("R9 no carried burst", c, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule